// File: doc/BRIEF.md
# Group-Two Skip and MQ Operate Unit

This unit executes the operate-class instructions of a 12-bit accumulator machine that carry opcode 7 with instruction bit 8 set. The word is then either a conditional-skip group or a multiplier-quotient (MQ) group, chosen by instruction bit 0. In the skip group the unit tests the incoming accumulator sign, the accumulator for zero and the link. It then clears the accumulator if asked, ORs in the front-panel switch word, and can raise a halt. In the MQ group it clears the accumulator if asked and then moves words between the accumulator and a 12-bit MQ register that the unit holds itself.

The accumulator result, the skip flag and the next program counter are combinational on the inputs, so the execute stage can consume them in the same cycle. The MQ register and the halt flag are state, and they change on the clock edge that ends a valid operation. Instruction bits are numbered with bit 0 as the least significant bit.

Top module: `opr2_unit`

## Requirements
- R1: An operation takes effect only when `op_valid` is 1, `instr[11:9]` is 3'b111 and `instr[8]` is 1. In any other cycle `acc_out` equals `acc_in`, `skip_o` is 0, `pc_out` equals `pc_in`, and neither `mq_o` nor `halt_o` changes.
- R2: Skip group (`instr[0]`=0) with sense bit `instr[3]`=0: skip when any selected test holds. The tests are `instr[6]` with sign `acc_in[11]`=1, `instr[5]` with `acc_in`==0, and `instr[4]` with `link_in`=1.
- R3: Skip group with `instr[3]`=1: skip only when every selected test holds. The tests are `instr[6]` with `acc_in[11]`=0, `instr[5]` with `acc_in`!=0, and `instr[4]` with `link_in`=0. When no test is selected the skip is unconditional.
- R4: The skip tests use the incoming accumulator, before any clear in the same instruction.
- R5: In the skip group, `acc_out` is the accumulator after the clear (`instr[7]`), with `switch_in` ORed in when `instr[2]`=1.
- R6: A skip-group operation with `instr[1]`=1 sets `halt_o` on the following clock edge.
- R7: Once set, `halt_o` stays set until `rst` is asserted.
- R8: MQ group (`instr[0]`=1): clear is applied first (`instr[7]`). Then, in parallel, `instr[6]` ORs the old MQ into the accumulator and `instr[4]` loads MQ from the cleared accumulator and removes that value from the accumulator. `acc_out` is combinational; `mq_o` updates on the following edge.
- R9: In the MQ group with both `instr[6]` and `instr[4]` set and no clear, the accumulator and MQ are exchanged.
- R10: When `skip_o` is 1, `pc_out` is `pc_in` + 1, wrapping to zero within the counter width. Otherwise it equals `pc_in`.
- R11: Reset clears `mq_o` and `halt_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An instruction is presented this cycle |
| instr | input | 12 | Instruction word |
| acc_in | input | DATA_W | Current accumulator |
| link_in | input | 1 | Current link bit |
| switch_in | input | DATA_W | Switch register word |
| pc_in | input | PC_W | Already-incremented program counter |
| acc_out | output | DATA_W | New accumulator |
| skip_o | output | 1 | Skip taken |
| pc_out | output | PC_W | Next program counter after any skip |
| halt_o | output | 1 | Sticky halt flag |
| mq_o | output | DATA_W | MQ register contents |

## Verification
The accumulator result, skip flag and next counter are due in the same cycle as the instruction. The bench samples them one nanosecond after it drives its inputs on the falling edge. MQ and halt changes are due one rising edge later, so the bench reads them on the next falling edge, after it has withdrawn `op_valid`. The skip group is swept over all 128 combinations of bits 7 to 1 against sign, zero and link patterns. All eight clear, OR and load combinations of the MQ group are run from a known preloaded MQ.

// File: rtl/opr2_pkg.sv
package opr2_pkg;

    localparam int INSTR_W = 12;

    // Decoded control for one operate word
    typedef struct packed {
        logic ours;     // opcode 7 with bit 8 set and valid
        logic mq_grp;   // MQ group when set, skip group otherwise
        logic cla;
        logic t_sign;
        logic t_zero;
        logic t_link;
        logic all_sense;
        logic osr;
        logic hlt;
        logic mqa;
        logic mql;
    } opr_ctl_t;

    function automatic opr_ctl_t decode_opr(input logic valid,
                                            input logic [INSTR_W-1:0] ir);
        opr_ctl_t c;
        c.ours      = valid && (ir[11:9] == 3'b111) && ir[8];
        c.mq_grp    = ir[0];
        c.cla       = ir[7];
        c.t_sign    = ir[6];
        c.t_zero    = ir[5];
        c.t_link    = ir[4];
        c.all_sense = ir[3];
        c.osr       = ir[2];
        c.hlt       = ir[1];
        c.mqa       = ir[6];
        c.mql       = ir[4];
        return c;
    endfunction

endpackage

// File: rtl/opr2_skip_eval.sv
module opr2_skip_eval
    import opr2_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  opr_ctl_t          ctl,
    input  logic [DATA_W-1:0] acc,
    input  logic              link,
    output logic              skip
);
    logic sign_neg;
    logic acc_zero;
    logic any_hit;
    logic all_hit;

    always_comb begin
        sign_neg = acc[DATA_W-1];
        acc_zero = (acc == '0);
        any_hit  = (ctl.t_sign & sign_neg) | (ctl.t_zero & acc_zero) |
                   (ctl.t_link & link);
        all_hit  = (~ctl.t_sign | ~sign_neg) & (~ctl.t_zero | ~acc_zero) &
                   (~ctl.t_link | ~link);
        skip     = ctl.ours & ~ctl.mq_grp & (ctl.all_sense ? all_hit : any_hit);
    end
endmodule

// File: rtl/opr2_acc_path.sv
module opr2_acc_path
    import opr2_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  opr_ctl_t          ctl,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] sw,
    input  logic [DATA_W-1:0] mq,
    output logic [DATA_W-1:0] acc_new,
    output logic [DATA_W-1:0] mq_new,
    output logic              mq_we
);
    logic [DATA_W-1:0] cleared;

    always_comb begin
        cleared = ctl.cla ? '0 : acc;
        acc_new = acc;
        mq_new  = mq;
        mq_we   = 1'b0;
        if (ctl.ours) begin
            if (ctl.mq_grp) begin
                acc_new = (ctl.mqa ? mq : '0) | (ctl.mql ? '0 : cleared);
                mq_new  = cleared;
                mq_we   = ctl.mql;
            end else begin
                acc_new = cleared | (ctl.osr ? sw : '0);
            end
        end
    end
endmodule

// File: rtl/opr2_state.sv
module opr2_state
    import opr2_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  opr_ctl_t          ctl,
    input  logic [DATA_W-1:0] mq_new,
    input  logic              mq_we,
    output logic [DATA_W-1:0] mq,
    output logic              halt
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mq   <= '0;
            halt <= 1'b0;
        end else begin
            if (mq_we) mq <= mq_new;
            if (ctl.ours && !ctl.mq_grp && ctl.hlt) halt <= 1'b1;
        end
    end
endmodule

// File: rtl/opr2_unit.sv
module opr2_unit
    import opr2_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int PC_W   = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [11:0]       instr,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              link_in,
    input  logic [DATA_W-1:0] switch_in,
    input  logic [PC_W-1:0]   pc_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              skip_o,
    output logic [PC_W-1:0]   pc_out,
    output logic              halt_o,
    output logic [DATA_W-1:0] mq_o
);
    opr_ctl_t          ctl;
    logic [DATA_W-1:0] mq_new;
    logic              mq_we;

    assign ctl = decode_opr(op_valid, instr);

    opr2_skip_eval #(.DATA_W(DATA_W)) u_skip (
        .ctl(ctl), .acc(acc_in), .link(link_in), .skip(skip_o)
    );

    opr2_acc_path #(.DATA_W(DATA_W)) u_acc (
        .ctl(ctl), .acc(acc_in), .sw(switch_in), .mq(mq_o),
        .acc_new(acc_out), .mq_new(mq_new), .mq_we(mq_we)
    );

    opr2_state #(.DATA_W(DATA_W)) u_state (
        .clk(clk), .rst(rst), .ctl(ctl), .mq_new(mq_new), .mq_we(mq_we),
        .mq(mq_o), .halt(halt_o)
    );

    assign pc_out = skip_o ? pc_in + PC_W'(1) : pc_in;
endmodule

// File: rtl/opr2_unit_chk.sv
module opr2_unit_chk #(
    parameter int DATA_W = 12,
    parameter int PC_W   = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [11:0]       instr,
    input logic [DATA_W-1:0] acc_in,
    input logic [DATA_W-1:0] acc_out,
    input logic              skip_o,
    input logic              halt_o,
    input logic [DATA_W-1:0] mq_o
);
    logic hit, mq_load, g2_halt;
    assign hit     = op_valid && (instr[11:8] == 4'hF);
    assign mq_load = hit && instr[0] && instr[4];
    assign g2_halt = hit && !instr[0] && instr[1];

    p_passthru_r1: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (acc_out == acc_in && !skip_o));

    p_skip_group_r1: assert property (@(posedge clk) disable iff (rst)
        skip_o |-> (hit && !instr[0]));

    p_halt_set_r6: assert property (@(posedge clk) disable iff (rst)
        g2_halt |=> halt_o);

    p_halt_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> halt_o);

    p_mq_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !mq_load |=> $stable(mq_o));

    p_mq_load_r8: assert property (@(posedge clk) disable iff (rst)
        (mq_load && !instr[7]) |=> (mq_o == $past(acc_in)));
endmodule

bind opr2_unit opr2_unit_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_opr2_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .instr(instr),
    .acc_in(acc_in), .acc_out(acc_out), .skip_o(skip_o),
    .halt_o(halt_o), .mq_o(mq_o)
);

// File: tb/test_opr2_unit.sv
`timescale 1ns/1ps
module test_opr2_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [11:0] instr = '0;
    logic [11:0] acc_in = '0;
    logic        link_in = 1'b0;
    logic [11:0] switch_in = '0;
    logic [11:0] pc_in = '0;
    logic [11:0] acc_out;
    logic        skip_o;
    logic [11:0] pc_out;
    logic        halt_o;
    logic [11:0] mq_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    opr2_unit i_opr2_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .instr(instr),
        .acc_in(acc_in), .link_in(link_in), .switch_in(switch_in),
        .pc_in(pc_in), .acc_out(acc_out), .skip_o(skip_o), .pc_out(pc_out),
        .halt_o(halt_o), .mq_o(mq_o)
    );

    task automatic check(input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive on falling edge, leave 1 ns for combinational outputs
    task automatic drive(input logic v, input logic [11:0] ir,
                         input logic [11:0] a, input logic l,
                         input logic [11:0] s, input logic [11:0] p);
        @(negedge clk);
        op_valid = v; instr = ir; acc_in = a; link_in = l;
        switch_in = s; pc_in = p;
        #1;
    endtask

    // pass one rising edge, withdraw the op, sample state
    task automatic settle();
        @(negedge clk);
        op_valid = 1'b0;
        #1;
    endtask

    function automatic logic exp_skip(input logic [11:0] ir,
                                      input logic [11:0] a, input logic l);
        logic neg, zer;
        neg = a[11];
        zer = (a == 0);
        if (!ir[3])
            return (ir[6] && neg) || (ir[5] && zer) || (ir[4] && l);
        return (!ir[6] || !neg) && (!ir[5] || !zer) && (!ir[4] || !l);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [11:0] m;
        logic [11:0] accs [4];
        accs[0] = 12'o0000; accs[1] = 12'o4000;
        accs[2] = 12'o0001; accs[3] = 12'o7777;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R11 reset mq", mq_o, 0);
        check("R11 reset halt", halt_o, 0);

        // R1: foreign and invalid words change nothing
        drive(1, 12'o7200, 12'o1234, 1, 12'o7777, 12'o0100);
        check("R1 group1 acc", acc_out, 12'o1234);
        check("R1 group1 skip", skip_o, 0);
        check("R1 group1 pc", pc_out, 12'o0100);
        drive(0, 12'hF1A, 12'o0000, 0, 12'o7777, 12'o0100);
        check("R1 invalid acc", acc_out, 12'o0000);
        check("R1 invalid skip", skip_o, 0);
        settle();
        check("R1 invalid mq", mq_o, 0);
        check("R1 invalid halt", halt_o, 0);

        // R6/R7: halt is sticky until reset
        drive(1, 12'hF02, 12'o0000, 0, 0, 0);
        settle();
        check("R6 halt set", halt_o, 1);
        drive(1, 12'hF00, 12'o0000, 0, 0, 0);
        settle();
        check("R7 halt stays", halt_o, 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        check("R11 halt cleared by reset", halt_o, 0);

        // R10: skip wraps the counter
        drive(1, 12'hF08, 12'o0000, 0, 0, 12'o7777);
        check("R10 unconditional skip", skip_o, 1);
        check("R10 pc wrap", pc_out, 12'o0000);

        // R2..R5 sweep of skip group bits 7..1
        for (int b = 0; b < 128; b++) begin
            for (int ai = 0; ai < 4; ai++) begin
                for (int l = 0; l < 2; l++) begin
                    logic [11:0] ir, ea;
                    logic es;
                    ir = {4'hF, b[6:0], 1'b0};
                    drive(1, ir, accs[ai], l[0], 12'o5252, 12'o0400);
                    es = exp_skip(ir, accs[ai], l[0]);
                    ea = (ir[7] ? 12'o0000 : accs[ai]) | (ir[2] ? 12'o5252 : 12'o0000);
                    check(ir[3] ? "R3 all-sense skip" : "R2 any-sense skip", skip_o, es);
                    if (ir[7]) check("R4 skip before clear", skip_o, es);
                    check("R5 acc clear then or", acc_out, ea);
                    check("R10 pc", pc_out, es ? 12'o0401 : 12'o0400);
                end
            end
        end
        settle();

        // R8/R9: MQ group, all combinations of clear, or-in and load
        for (int k = 0; k < 8; k++) begin
            for (int v = 0; v < 2; v++) begin
                logic [11:0] a, a0, ea, em, ir;
                a = v ? 12'o7070 : 12'o1234;
                drive(1, 12'hF11, 12'o0707, 0, 0, 0);
                check("R8 mql load acc", acc_out, 0);
                settle();
                check("R8 preload mq", mq_o, 12'o0707);
                m = 12'o0707;
                ir = 12'hF01 | (k[2] ? 12'h080 : 0) | (k[1] ? 12'h040 : 0) |
                     (k[0] ? 12'h010 : 0);
                a0 = k[2] ? 12'o0000 : a;
                ea = (k[1] ? m : 12'o0000) | (k[0] ? 12'o0000 : a0);
                em = k[0] ? a0 : m;
                drive(1, ir, a, 1, 12'o7777, 12'o0020);
                check("R8 mq group acc", acc_out, ea);
                check("R8 mq group no skip", skip_o, 0);
                if (k == 3) check("R9 swap acc", acc_out, m);
                settle();
                check("R8 mq group mq", mq_o, em);
                if (k == 3) check("R9 swap mq", mq_o, a);
            end
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule